// File: doc/BRIEF.md
# Operand Register-Dependency Decoder

This block turns an instruction's opcode property word and its ModR/M and SIB bytes into three register masks. A pairing or scheduling stage uses them to spot hazards between instructions. The masks are the registers used to form the memory address, the registers the instruction reads, and the registers it writes. The property word comes from a table held elsewhere, and comparing masks across instructions happens downstream; neither is part of this block.

All three masks share one 10-bit format. Bit n (n = 0..7) stands for general register n in the usual encoding: AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. Bit 8 marks implicit stack use. Bit 9 marks use of the MMX shift/pack or multiply unit. The decode is purely combinational. A `valid_i` strobe captures the result into output registers, so it appears one cycle later.

Top module: `regdep_decoder`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and all three masks are 0.
- R2: `valid_o` equals `valid_i` delayed by one clock. A strobe captures all three masks, which show one cycle later. While `valid_i` is low the masks hold their last values.
- R3: Property bit 0 (read) and bit 2 (write) select the REG-field register, which is ModR/M bits 5:3. Property bit 1 (read) and bit 3 (write) select the R/M-field register, which is ModR/M bits 2:0. With `byte_op_i` high, the index is cut to its low two bits before the one-hot is formed.
- R4: Property bits 11:4 are OR-ed into source mask bits 7:0, and property bits 19:12 into destination mask bits 7:0.
- R5: Address mask bits 7:0 are zero unless property bit 20 (ModR/M present) is set and the mod field (ModR/M bits 7:6) is not 3.
- R6: With 32-bit addressing and R/M not 4, the R/M register enters the address mask, except when mod=0 and R/M=5.
- R7: With 32-bit addressing and R/M=4, the SIB base (SIB bits 2:0) enters the address mask unless it is 5, and in that case nothing enters. When the base does enter, the SIB index (bits 5:3) also enters unless it is 4.
- R8: With 16-bit addressing, mod=0 with R/M=6 adds no register. Otherwise R/M 0..7 adds BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX.
- R9: Property bit 21 (implicit stack) sets address mask bit 8, and sets destination mask bits 8 and 4.
- R10: Property bit 22 or bit 23 sets bit 9 of both the source and the destination masks.
- R11: The source mask includes every bit of the address mask. The destination mask never receives the address-mask contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Capture strobe for the current operands |
| prop_i | input | 36 | Opcode property word |
| modrm_i | input | 8 | ModR/M byte |
| sib_i | input | 8 | SIB byte |
| byte_op_i | input | 1 | 8-bit operand size |
| addr32_i | input | 1 | 32-bit addressing |
| valid_o | output | 1 | Masks are from a strobe one cycle earlier |
| addr_mask_o | output | 10 | Address-register mask |
| src_mask_o | output | 10 | Source-dependency mask |
| dst_mask_o | output | 10 | Destination-dependency mask |

## Verification
The only state is the output register, so any mistake shows up in the masks one cycle after the strobe. A wrong exclusion rule changes one or two address bits for particular ModR/M or SIB codes, and that change repeats in the source mask. For this reason every ModR/M value is driven under both address sizes, and every SIB value is driven for each memory mod with R/M=4. A broken hold path shows up as masks that change in a cycle with no strobe.

// File: rtl/regdep_pkg.sv
package regdep_pkg;
  localparam int unsigned REG_N   = 8;
  localparam int unsigned IDX_W   = $clog2(REG_N);
  localparam int unsigned MASK_W  = REG_N + 2;
  localparam int unsigned PROP_W  = 36;

  // property word fields
  localparam int unsigned P_RD_REG  = 0;
  localparam int unsigned P_RD_RM   = 1;
  localparam int unsigned P_WR_REG  = 2;
  localparam int unsigned P_WR_RM   = 3;
  localparam int unsigned P_RD_LO   = 4;
  localparam int unsigned P_WR_LO   = P_RD_LO + REG_N;
  localparam int unsigned P_MODRM   = P_WR_LO + REG_N;
  localparam int unsigned P_STACK   = P_MODRM + 1;
  localparam int unsigned P_MMX_SP  = P_STACK + 1;
  localparam int unsigned P_MMX_MUL = P_MMX_SP + 1;

  // mask bits
  localparam int unsigned M_STACK = REG_N;
  localparam int unsigned M_MMX   = REG_N + 1;
  localparam int unsigned R_BX = 3, R_SP = 4, R_BP = 5, R_SI = 6, R_DI = 7;

  typedef logic [MASK_W-1:0] mask_t;

  typedef struct packed {
    mask_t addr;
    mask_t src;
    mask_t dst;
  } dep_masks_t;
endpackage

// File: rtl/regdep_field_dec.sv
module regdep_field_dec
  import regdep_pkg::*;
(
  input  logic [7:0]       modrm_i,
  input  logic             byte_op_i,
  output logic [REG_N-1:0] reg_oh_o,
  output logic [REG_N-1:0] rm_oh_o
);
  logic [IDX_W-1:0] idx [2];

  assign idx[0] = modrm_i[5:3];
  assign idx[1] = modrm_i[2:0];

  for (genvar g = 0; g < 2; g++) begin : g_fld
    logic [IDX_W-1:0] eff;
    logic [REG_N-1:0] oh;
    // byte operands: AL..BL / AH..BH alias onto registers 0..3
    assign eff = byte_op_i ? {1'b0, idx[g][1:0]} : idx[g];
    always_comb begin
      oh = '0;
      oh[eff] = 1'b1;
    end
    if (g == 0) begin : g_reg
      assign reg_oh_o = oh;
    end else begin : g_rm
      assign rm_oh_o = oh;
    end
  end
endmodule

// File: rtl/regdep_addr_dec.sv
module regdep_addr_dec
  import regdep_pkg::*;
(
  input  logic        has_modrm_i,
  input  logic        stack_i,
  input  logic        addr32_i,
  input  logic [7:0]  modrm_i,
  input  logic [7:0]  sib_i,
  output mask_t       addr_mask_o
);
  logic [1:0]       md;
  logic [IDX_W-1:0] rm, base, index;

  assign md    = modrm_i[7:6];
  assign rm    = modrm_i[2:0];
  assign base  = sib_i[2:0];
  assign index = sib_i[5:3];

  mask_t m32, m16;

  always_comb begin
    m32 = '0;
    if (rm == 3'd4) begin
      if (base != 3'd5) begin
        m32[base] = 1'b1;
        if (index != 3'd4) m32[index] = 1'b1;
      end
    end else if (!(md == 2'd0 && rm == 3'd5)) begin
      m32[rm] = 1'b1;
    end
  end

  always_comb begin
    m16 = '0;
    if (!(md == 2'd0 && rm == 3'd6)) begin
      unique case (rm)
        3'd0: begin m16[R_BX] = 1'b1; m16[R_SI] = 1'b1; end
        3'd1: begin m16[R_BX] = 1'b1; m16[R_DI] = 1'b1; end
        3'd2: begin m16[R_BP] = 1'b1; m16[R_SI] = 1'b1; end
        3'd3: begin m16[R_BP] = 1'b1; m16[R_DI] = 1'b1; end
        3'd4: m16[R_SI] = 1'b1;
        3'd5: m16[R_DI] = 1'b1;
        3'd6: m16[R_BP] = 1'b1;
        default: m16[R_BX] = 1'b1;
      endcase
    end
  end

  always_comb begin
    addr_mask_o = '0;
    if (has_modrm_i && md != 2'd3) addr_mask_o = addr32_i ? m32 : m16;
    if (stack_i) addr_mask_o[M_STACK] = 1'b1;
  end
endmodule

// File: rtl/regdep_decoder.sv
module regdep_decoder
  import regdep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PROP_W-1:0] prop_i,
  input  logic [7:0]        modrm_i,
  input  logic [7:0]        sib_i,
  input  logic              byte_op_i,
  input  logic              addr32_i,
  output logic              valid_o,
  output logic [MASK_W-1:0] addr_mask_o,
  output logic [MASK_W-1:0] src_mask_o,
  output logic [MASK_W-1:0] dst_mask_o
);
  logic [REG_N-1:0] reg_oh, rm_oh;
  mask_t            addr_m;
  dep_masks_t       nxt, q;
  logic             mmx;
  logic             unused_prop;

  assign unused_prop = ^prop_i[PROP_W-1:P_MMX_MUL+1];

  regdep_field_dec u_fld (
    .modrm_i   (modrm_i),
    .byte_op_i (byte_op_i),
    .reg_oh_o  (reg_oh),
    .rm_oh_o   (rm_oh)
  );

  regdep_addr_dec u_addr (
    .has_modrm_i (prop_i[P_MODRM]),
    .stack_i     (prop_i[P_STACK]),
    .addr32_i    (addr32_i),
    .modrm_i     (modrm_i),
    .sib_i       (sib_i),
    .addr_mask_o (addr_m)
  );

  assign mmx = prop_i[P_MMX_SP] | prop_i[P_MMX_MUL];

  always_comb begin
    nxt.addr = addr_m;

    nxt.src = '0;
    nxt.src[REG_N-1:0] = (prop_i[P_RD_REG] ? reg_oh : '0)
                       | (prop_i[P_RD_RM]  ? rm_oh  : '0)
                       | prop_i[P_RD_LO +: REG_N];
    nxt.src[M_MMX] = mmx;
    nxt.src = nxt.src | addr_m;

    nxt.dst = '0;
    nxt.dst[REG_N-1:0] = (prop_i[P_WR_REG] ? reg_oh : '0)
                       | (prop_i[P_WR_RM]  ? rm_oh  : '0)
                       | prop_i[P_WR_LO +: REG_N];
    nxt.dst[M_MMX] = mmx;
    if (prop_i[P_STACK]) begin
      nxt.dst[M_STACK] = 1'b1;
      nxt.dst[R_SP]    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q       <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q <= nxt;
    end
  end

  assign addr_mask_o = q.addr;
  assign src_mask_o  = q.src;
  assign dst_mask_o  = q.dst;
endmodule

// File: rtl/regdep_decoder_chk.sv
module regdep_decoder_chk
  import regdep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [PROP_W-1:0] prop_i,
  input logic              valid_o,
  input logic [MASK_W-1:0] addr_mask_o,
  input logic [MASK_W-1:0] src_mask_o,
  input logic [MASK_W-1:0] dst_mask_o
);
  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(src_mask_o) && $stable(dst_mask_o) && $stable(addr_mask_o));

  // R5
  no_modrm_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !prop_i[P_MODRM] |=> addr_mask_o[REG_N-1:0] == '0);

  // R9
  stack_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && prop_i[P_STACK] |=> addr_mask_o[M_STACK] && dst_mask_o[M_STACK] && dst_mask_o[R_SP]);

  // R10
  mmx_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (prop_i[P_MMX_SP] || prop_i[P_MMX_MUL]) |=> src_mask_o[M_MMX] && dst_mask_o[M_MMX]);

  // R11
  addr_in_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_mask_o & ~src_mask_o) == '0);
endmodule

bind regdep_decoder regdep_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .prop_i      (prop_i),
  .valid_o     (valid_o),
  .addr_mask_o (addr_mask_o),
  .src_mask_o  (src_mask_o),
  .dst_mask_o  (dst_mask_o)
);

// File: tb/tb_regdep_decoder.sv
module tb_regdep_decoder;
  typedef struct {
    logic [9:0] a;
    logic [9:0] s;
    logic [9:0] d;
    string      tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [35:0] prop = '0;
  logic [7:0]  modrm = '0, sib = '0;
  logic        b8 = 1'b0, a32 = 1'b0;
  logic        vo;
  logic [9:0]  am, sm, dm;

  int checks = 0, errors = 0, pushed = 0, popped = 0;
  item_t q[$];
  item_t last;
  bit done = 0;

  always #5 clk = ~clk;

  regdep_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .prop_i(prop),
    .modrm_i(modrm), .sib_i(sib), .byte_op_i(b8), .addr32_i(a32),
    .valid_o(vo), .addr_mask_o(am), .src_mask_o(sm), .dst_mask_o(dm)
  );

  function automatic item_t model(logic [35:0] p, logic [7:0] mr, logic [7:0] sb,
                                  logic bo, logic w32, string tag);
    item_t it;
    int r_reg, r_rm, md, rm, bs, ix;
    logic [9:0] ad = '0;
    r_reg = mr[5:3]; r_rm = mr[2:0];
    if (bo) begin r_reg = r_reg % 4; r_rm = r_rm % 4; end
    md = mr[7:6]; rm = mr[2:0]; bs = sb[2:0]; ix = sb[5:3];
    if (p[20] && md != 3) begin
      if (w32) begin
        if (rm == 4) begin
          if (bs != 5) begin
            ad[bs] = 1;
            if (ix != 4) ad[ix] = 1;
          end
        end else if (!(md == 0 && rm == 5)) ad[rm] = 1;
      end else if (!(md == 0 && rm == 6)) begin
        // BX=3 SP=4 BP=5 SI=6 DI=7
        if (rm == 0 || rm == 1 || rm == 7) ad[3] = 1;
        if (rm == 2 || rm == 3 || rm == 6) ad[5] = 1;
        if (rm == 0 || rm == 2 || rm == 4) ad[6] = 1;
        if (rm == 1 || rm == 3 || rm == 5) ad[7] = 1;
      end
    end
    if (p[21]) ad[8] = 1;
    it.a = ad;
    it.s = {1'b0, 1'b0, p[11:4]} | ad;
    it.d = {1'b0, 1'b0, p[19:12]};
    if (p[0]) it.s[r_reg] = 1;
    if (p[1]) it.s[r_rm] = 1;
    if (p[2]) it.d[r_reg] = 1;
    if (p[3]) it.d[r_rm] = 1;
    if (p[22] || p[23]) begin it.s[9] = 1; it.d[9] = 1; end
    if (p[21]) begin it.d[8] = 1; it.d[4] = 1; end
    it.tag = tag;
    return it;
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [35:0] p, logic [7:0] mr, logic [7:0] sb,
                       logic bo, logic w32, string tag);
    item_t it;
    @(negedge clk);
    prop = p; modrm = mr; sib = sb; b8 = bo; a32 = w32; valid = 1'b1;
    it = model(p, mr, sb, bo, w32, tag);
    q.push_back(it);
    last = it;
    pushed++;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && vo) begin
      item_t e;
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected_output expected=none");
      end else begin
        e = q.pop_front();
        popped++;
        check({e.tag, " addr"}, am, e.a);
        check("R11 src", sm, e.s);
        check({e.tag, " dst"}, dm, e.d);
      end
    end
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] rp;
    // R1: state under reset
    prop = '1; modrm = 8'h44; valid = 1'b1;
    #12;
    check("R1 valid", {9'd0, vo}, 10'd0);
    check("R1 addr", am, '0);
    check("R1 src", sm, '0);
    check("R1 dst", dm, '0);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b1;

    // R8: 16-bit addressing, every ModR/M
    for (int i = 0; i < 256; i++)
      drive(36'h1_0000B, 8'(i), 8'h00, 1'b0, 1'b0, (i[7:6] == 2'd3) ? "R5" : "R8");
    // R6: 32-bit addressing, every ModR/M
    for (int i = 0; i < 256; i++)
      drive(36'h1_00005, 8'(i), 8'(i) ^ 8'h5a, 1'b0, 1'b1,
            (i[7:6] == 2'd3) ? "R5" : (i[2:0] == 3'd4) ? "R7" : "R6");
    // R7: every SIB for each memory mod with R/M=4
    for (int md = 0; md < 3; md++)
      for (int s = 0; s < 256; s++)
        drive(36'h1_00000, {2'(md), 3'(s % 8), 3'd4}, 8'(s), 1'b0, 1'b1, "R7");
    // R5: no ModR/M byte present
    for (int i = 0; i < 32; i++)
      drive(36'h0_0000F, 8'($urandom), 8'($urandom), 1'b0, i[0], "R5");
    // R3: byte operand index cut
    for (int i = 0; i < 256; i++)
      drive(36'h0_0000F, 8'(i), 8'h00, i[2] ^ i[6], 1'b0, "R3");
    // R4 / R9 / R10: random property words
    for (int i = 0; i < 300; i++) begin
      rp = {$urandom, $urandom} & 36'h0_FFFF_FFFF;
      drive(rp, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            rp[21] ? "R9" : (rp[22] | rp[23]) ? "R10" : "R4");
    end
    // R9, R10 directed
    drive(36'h2_00000, 8'hC0, 8'h00, 1'b0, 1'b1, "R9");
    drive(36'h4_00000, 8'h00, 8'h00, 1'b0, 1'b0, "R10");
    drive(36'h8_00000, 8'h00, 8'h00, 1'b0, 1'b0, "R10");

    // R2: masks hold with no strobe
    idle();
    prop = '1; modrm = 8'h00; sib = 8'h00; a32 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold valid", {9'd0, vo}, 10'd0);
    check("R2 hold addr", am, last.a);
    check("R2 hold src", sm, last.s);
    check("R2 hold dst", dm, last.d);
    check("R2 count", 10'(pushed - popped), 10'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule